// File: doc/BRIEF.md
# MMU Access Permission Checker with Fault Status

This block sits behind a page-table walker. For each memory access it checks the kind of access against the 3-bit permission field of the leaf page entry. It then reports one of two things: an error code that marks a protection or privilege fault, or the read/write/execute rights that a TLB may load for the page. The walker hands over the leaf entry's permission field and modified bit, the faulting virtual address, and its own translation-error code. A non-zero walker code is treated as a fault before any permission check is made.

The block keeps a fault status register and a fault address register. Both are updated on a clock edge in which the check strobe is high and the access faults. A software read strobe clears the status register. The status register carries an overflow flag, which is set when a second fault arrives before the first one was read. A control input selects a no-fault mode in which user permission errors are ignored. In that mode, and whenever traps are disabled, a faulting access is granted full rights instead of raising a trap.

Top module: `mmu_perm_check`

## Requirements
- R1: The access index is {acc_write, acc_ifetch, ~acc_user}. The permission error is 3 (privilege violation) for a user access to permission 6 or 7. Otherwise it is 2 (protection error) when the access needs a right missing from the privilege level's rights set: a read needs R, a write needs W, a fetch needs X, and a write together with a fetch needs both W and X. Otherwise it is 0. This error appears on err_code[1:0] in the same cycle, with the upper bits zero.
- R2: A non-zero walk_err always makes the access a fault, and err_code then equals walk_err. This holds whatever the permission field and whatever the no-fault setting.
- R3: When the access does not fault, rights (bit 2 = R, bit 1 = W, bit 0 = X) are taken from the permission value 0..7. For a supervisor access they are R, RW, RX, RWX, X, RW, RX, RWX. For a user access they are R, RW, RX, RWX, X, R, none, none.
- R4: When modified is 0, the W right is never granted to an access that does not fault.
- R5: When nofault_en is 1, a user access with a permission error does not fault: err_code is 0 and rights follow R3/R4. Supervisor permission errors are not exempt.
- R6: On a clock edge with chk_valid high and a fault, the next value of fsr is built from three terms. The first is 1 if the old fsr was non-zero (overflow, bit 0). The second is the access index at bits 7:5. The third is err_code with bit 1 set. These are ORed together. far takes vaddr on the same edge.
- R7: When a faulting access has nofault_en = 1 or traps_en = 0, rights is 3'b111 and no trap is raised. Otherwise rights is 0, and either trap_ifetch (fetch) or trap_data (data) is high while chk_valid is high.
- R8: fsr_rd clears fsr to 0 on the next edge. If a fault is recorded on that same edge, it is recorded without the overflow flag.
- R9: Reset clears fsr and far. Without chk_valid, a fault, or fsr_rd, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Access check strobe; allows register updates and traps |
| acc_write | input | 1 | Access writes |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access is made at user level |
| perm | input | 3 | Leaf entry permission field |
| modified | input | 1 | Leaf entry modified bit |
| vaddr | input | AW | Virtual address of the access |
| walk_err | input | 10 | Walker error code, 0 when the walk succeeded |
| nofault_en | input | 1 | No-fault mode control |
| traps_en | input | 1 | Traps enabled |
| fsr_rd | input | 1 | Fault status read strobe (clears) |
| err_code | output | 10 | Effective error code |
| rights | output | 3 | Granted rights {R,W,X} |
| trap_ifetch | output | 1 | Instruction fault trap request |
| trap_data | output | 1 | Data fault trap request |
| fsr | output | 10 | Fault status register |
| far | output | AW | Fault address register |

## Verification
err_code, rights and the two trap outputs are combinational. They are due in the same cycle as the access. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. fsr and far are due one rising edge after the faulting or reading strobe. The bench checks them at the following falling edge, after exactly one rising edge. Each directed step therefore covers a single register update.

// File: rtl/mmu_perm_check.sv
module mmu_perm_check #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_valid,
  input  logic          acc_write,
  input  logic          acc_ifetch,
  input  logic          acc_user,
  input  logic [2:0]    perm,
  input  logic          modified,
  input  logic [AW-1:0] vaddr,
  input  logic [9:0]    walk_err,
  input  logic          nofault_en,
  input  logic          traps_en,
  input  logic          fsr_rd,
  output logic [9:0]    err_code,
  output logic [2:0]    rights,
  output logic          trap_ifetch,
  output logic          trap_data,
  output logic [9:0]    fsr,
  output logic [AW-1:0] far
);
  localparam logic [2:0] RT_R = 3'b100;
  localparam logic [2:0] RT_W = 3'b010;
  localparam logic [2:0] RT_X = 3'b001;

  function automatic logic [2:0] level_rights(input logic user, input logic [2:0] p);
    case (p)
      3'd0: level_rights = RT_R;
      3'd1: level_rights = RT_R | RT_W;
      3'd2: level_rights = RT_R | RT_X;
      3'd3: level_rights = RT_R | RT_W | RT_X;
      3'd4: level_rights = RT_X;
      3'd5: level_rights = user ? RT_R : (RT_R | RT_W);
      3'd6: level_rights = user ? 3'b000 : (RT_R | RT_X);
      default: level_rights = user ? 3'b000 : (RT_R | RT_W | RT_X);
    endcase
  endfunction

  logic [2:0] idx, full, need, grant;
  logic [1:0] tbl_err, perm_err;
  logic       priv_bad, walk_bad, fault, override;

  assign idx      = {acc_write, acc_ifetch, ~acc_user};
  assign full     = level_rights(acc_user, perm);
  assign need     = {~acc_write & ~acc_ifetch, acc_write, acc_ifetch};
  assign priv_bad = acc_user & (perm[2:1] == 2'b11);
  assign tbl_err  = priv_bad ? 2'd3 : (|(need & ~full)) ? 2'd2 : 2'd0;
  assign perm_err = (nofault_en & acc_user) ? 2'd0 : tbl_err;
  assign walk_bad = |walk_err;
  assign fault    = walk_bad | (|perm_err);
  assign override = nofault_en | ~traps_en;
  assign grant    = modified ? full : (full & ~RT_W);

  assign err_code    = walk_bad ? walk_err : {8'd0, perm_err};
  assign rights      = !fault ? grant : (override ? 3'b111 : 3'b000);
  assign trap_ifetch = chk_valid & fault & ~override & acc_ifetch;
  assign trap_data   = chk_valid & fault & ~override & ~acc_ifetch;

  logic [9:0] fsr_base;
  assign fsr_base = fsr_rd ? 10'd0 : fsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr <= '0;
      far <= '0;
    end else if (chk_valid && fault) begin
      fsr <= {9'd0, |fsr_base} | {2'd0, idx, 5'd0} | err_code | 10'd2;
      far <= vaddr;
    end else if (fsr_rd) begin
      fsr <= '0;
    end
  end

  assert_trap_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ifetch, trap_data}));

  assert_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!modified && err_code == 10'd0) |-> !rights[1]);

  assert_far_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (trap_ifetch || trap_data)) |=> (far == $past(vaddr)));

  assert_fsr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && err_code != 10'd0) |=> fsr[1]);

  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && err_code != 10'd0 && fsr != 10'd0 && !fsr_rd) |=> fsr[0]);

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !(chk_valid && err_code != 10'd0)) |=> (fsr == 10'd0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_valid && !fsr_rd) |=> ($stable(fsr) && $stable(far)));
endmodule

// File: tb/mmu_perm_check_tb.sv
module mmu_perm_check_tb;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chk_valid = 0, acc_write = 0, acc_ifetch = 0, acc_user = 0;
  logic [2:0] perm = 0;
  logic modified = 0, nofault_en = 0, traps_en = 1, fsr_rd = 0;
  logic [AW-1:0] vaddr = 0;
  logic [9:0] walk_err = 0;
  logic [9:0] err_code, fsr;
  logic [2:0] rights;
  logic trap_ifetch, trap_data;
  logic [AW-1:0] far;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmu_perm_check #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_write(acc_write),
    .acc_ifetch(acc_ifetch), .acc_user(acc_user), .perm(perm), .modified(modified),
    .vaddr(vaddr), .walk_err(walk_err), .nofault_en(nofault_en), .traps_en(traps_en),
    .fsr_rd(fsr_rd), .err_code(err_code), .rights(rights), .trap_ifetch(trap_ifetch),
    .trap_data(trap_data), .fsr(fsr), .far(far));

  localparam logic [1:0] MAT [8][8] = '{
    '{2'd0,2'd0,2'd0,2'd0,2'd2,2'd0,2'd3,2'd3},
    '{2'd0,2'd0,2'd0,2'd0,2'd2,2'd0,2'd0,2'd0},
    '{2'd2,2'd2,2'd0,2'd0,2'd0,2'd2,2'd3,2'd3},
    '{2'd2,2'd2,2'd0,2'd0,2'd0,2'd2,2'd0,2'd0},
    '{2'd2,2'd0,2'd2,2'd0,2'd2,2'd2,2'd3,2'd3},
    '{2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0},
    '{2'd2,2'd2,2'd2,2'd0,2'd2,2'd2,2'd3,2'd3},
    '{2'd2,2'd2,2'd2,2'd0,2'd2,2'd2,2'd2,2'd0}};
  localparam logic [2:0] SUP_RT [8] = '{3'd4,3'd6,3'd5,3'd7,3'd1,3'd6,3'd5,3'd7};
  localparam logic [2:0] USR_RT [8] = '{3'd4,3'd6,3'd5,3'd7,3'd1,3'd4,3'd0,3'd0};

  // {w,i,u,perm[2:0],mod,nf,ten, err[1:0],rights[2:0],ti,td}
  localparam logic [15:0] VEC [12] = '{
    {1'b0,1'b0,1'b1,3'd4,1'b1,1'b0,1'b1, 2'd2,3'd0,1'b0,1'b1},
    {1'b0,1'b0,1'b1,3'd6,1'b1,1'b0,1'b1, 2'd3,3'd0,1'b0,1'b1},
    {1'b0,1'b0,1'b0,3'd5,1'b1,1'b0,1'b1, 2'd0,3'd6,1'b0,1'b0},
    {1'b0,1'b0,1'b0,3'd5,1'b0,1'b0,1'b1, 2'd0,3'd4,1'b0,1'b0},
    {1'b1,1'b0,1'b1,3'd1,1'b1,1'b0,1'b1, 2'd0,3'd6,1'b0,1'b0},
    {1'b0,1'b1,1'b1,3'd0,1'b1,1'b0,1'b1, 2'd2,3'd0,1'b1,1'b0},
    {1'b0,1'b1,1'b1,3'd0,1'b1,1'b0,1'b0, 2'd2,3'd7,1'b0,1'b0},
    {1'b0,1'b0,1'b1,3'd4,1'b1,1'b1,1'b1, 2'd0,3'd1,1'b0,1'b0},
    {1'b0,1'b1,1'b0,3'd5,1'b1,1'b1,1'b1, 2'd2,3'd7,1'b0,1'b0},
    {1'b0,1'b0,1'b1,3'd7,1'b1,1'b0,1'b1, 2'd3,3'd0,1'b0,1'b1},
    {1'b1,1'b0,1'b0,3'd7,1'b0,1'b0,1'b1, 2'd0,3'd5,1'b0,1'b0},
    {1'b0,1'b0,1'b1,3'd5,1'b1,1'b0,1'b1, 2'd0,3'd4,1'b0,1'b0}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic i, input logic u, input logic [2:0] p,
                        input logic m, input logic nf, input logic ten, input logic [9:0] we,
                        input logic [AW-1:0] va, input logic v, input logic rd);
    acc_write = w; acc_ifetch = i; acc_user = u; perm = p; modified = m;
    nofault_en = nf; traps_en = ten; walk_err = we; vaddr = va; chk_valid = v; fsr_rd = rd;
  endtask

  task automatic idle();
    chk_valid = 0; fsr_rd = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] e_err;
    logic [2:0] e_rt;
    logic e_fault, e_ovr;
    @(negedge clk); @(negedge clk);
    check("R9 reset fsr", fsr, 0);
    check("R9 reset far", far, 0);
    rst_n = 1;
    @(negedge clk);

    for (int n = 0; n < 12; n++) begin
      access(VEC[n][15], VEC[n][14], VEC[n][13], VEC[n][12:10], VEC[n][9], VEC[n][8],
             VEC[n][7], 10'd0, 32'h1000, 1'b1, 1'b0);
      #1;
      check("R1/R5 vector err", err_code, {8'd0, VEC[n][6:5]});
      check("R3/R4/R7 vector rights", rights, VEC[n][4:2]);
      check("R7 vector traps", {trap_ifetch, trap_data}, VEC[n][1:0]);
      @(negedge clk);
    end

    idle();
    for (int s = 0; s < 512; s++) begin
      access(s[8], s[7], s[6], s[5:3], s[2], s[1], s[0], 10'd0, 32'h0, 1'b0, 1'b0);
      #1;
      e_err = MAT[{s[8], s[7], ~s[6]}][s[5:3]];
      if (s[1] && s[6]) e_err = 2'd0;
      e_fault = (e_err != 0);
      e_ovr = s[1] | ~s[0];
      e_rt = s[6] ? USR_RT[s[5:3]] : SUP_RT[s[5:3]];
      if (!s[2]) e_rt = e_rt & 3'b101;
      if (e_fault) e_rt = e_ovr ? 3'b111 : 3'b000;
      check("R1 R5 matrix err", err_code, {8'd0, e_err});
      check("R3 R4 R7 matrix rights", rights, e_rt);
      @(negedge clk);
    end

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);

    access(0, 1, 1, 3'd0, 1, 0, 1, 10'd0, 32'hABCD_1000, 1, 0);
    @(negedge clk);
    check("R6 first fault fsr", fsr, 10'h042);
    check("R6 first fault far", far, 32'hABCD_1000);

    access(1, 0, 0, 3'd6, 1, 0, 1, 10'd0, 32'h2222_0000, 1, 0);
    @(negedge clk);
    check("R6 overflow fsr", fsr, 10'h0A3);
    check("R6 second far", far, 32'h2222_0000);

    access(0, 0, 0, 3'd3, 1, 0, 1, 10'd0, 32'h5555_5555, 1, 0);
    #1;
    check("R9 no-fault access traps", {trap_ifetch, trap_data}, 0);
    @(negedge clk);
    check("R9 no fault keeps fsr", fsr, 10'h0A3);
    check("R9 no fault keeps far", far, 32'h2222_0000);

    idle(); vaddr = 32'h7777_7777;
    @(negedge clk);
    check("R9 idle keeps far", far, 32'h2222_0000);

    fsr_rd = 1;
    @(negedge clk);
    check("R8 read clears fsr", fsr, 0);
    idle();

    access(0, 0, 1, 3'd7, 1, 1, 1, 10'h304, 32'h3000_0004, 1, 0);
    #1;
    check("R2 walk err passthrough", err_code, 10'h304);
    check("R2 R7 nofault walk rights", rights, 3'b111);
    check("R7 nofault no trap", {trap_ifetch, trap_data}, 0);
    @(negedge clk);
    check("R2 R6 walk fault fsr", fsr, 10'h306);
    check("R6 walk fault far", far, 32'h3000_0004);

    access(0, 0, 1, 3'd3, 1, 0, 1, 10'h104, 32'h0, 1, 0);
    #1;
    check("R2 walk err overrides allowed perm", err_code, 10'h104);
    check("R2 R7 walk trap data", {trap_ifetch, trap_data}, 2'b01);
    check("R7 trapping rights none", rights, 0);
    idle();
    @(negedge clk);
    fsr_rd = 1;
    @(negedge clk);
    idle();

    access(0, 0, 1, 3'd4, 1, 0, 1, 10'd0, 32'h4000_0000, 1, 0);
    @(negedge clk);
    check("R6 fault after clear fsr", fsr, 10'h002);
    access(0, 0, 1, 3'd7, 1, 0, 1, 10'd0, 32'h4444_0000, 1, 1);
    @(negedge clk);
    check("R8 read with fault no overflow", fsr, 10'h003);
    check("R8 far on read+fault", far, 32'h4444_0000);
    idle();

    access(0, 0, 1, 3'd7, 1, 0, 1, 10'd0, 32'h0, 0, 0);
    #1;
    check("R7 trap needs chk_valid", {trap_ifetch, trap_data}, 0);
    idle();
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule